// File: doc/BRIEF.md
# Clear-on-read interrupt aggregator

This block gathers event flags from eight sources into one active-low interrupt line for a host processor. The sources are four general-purpose pins plus ring-monitor, detect, sync-loss and ring-detect inputs. Each source latches a flag on a rising edge of its input. The flags sit in an 8-bit status register. The host reads that register over a simple single-cycle register bus, and the read clears it.

An enable register selects which latched flags may pull the interrupt low. Masked flags still latch. A direction register marks general-purpose pins as outputs. A pin in output mode neither latches a flag nor contributes to the interrupt. The interrupt line is registered, so it changes only at clock edges.

Top module: `irq_collector`

## Requirements
- R1: After reset the status register reads 0xE0, the enable register 0x00 and the direction register 0x00, and irq_n_o is high.
- R2: A rising edge on src_i[k] sets status bit k. The bit map is: bits 7..4 are general-purpose pins 7..4, bit 3 is ring monitor, bit 2 is detect, bit 1 is sync loss and bit 0 is ring detect.
- R3: A latched flag stays set until the status register is read. An input held high after a clear does not set the flag again.
- R4: A read at address 0x03 returns the status value in the same cycle. The register is then zero from the next cycle on, unless a new event arrived.
- R5: An event whose rising edge falls in the same cycle as a clearing read is not lost. It is absent from that read's data and present in the next read.
- R6: irq_n_o is low only when some flag is set whose bit is also set in the enable register (address 0x0A). Flags latch whether or not they are enabled, and enabled flags are ORed together.
- R7: A direction register bit at 1 (address 0x0B, bits 7..4) makes the matching pin an output. Such a pin latches no flag, and any flag it already holds no longer drives irq_n_o.
- R8: irq_n_o is registered. It falls at the clock edge that latches an enabled event. It rises at the clock edge that ends a clearing read when no enabled flag remains. After an enable change, it follows one edge later.
- R9: The enable and direction registers read back what was written. A write to address 0x03 leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Event source inputs, bit map as in R2 |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The embedded assertions check several rules on every cycle:
- a status bit never appears on an input that is low;
- flags never vanish without a read;
- a clearing read leaves only that cycle's new events;
- output-mode pins never latch;
- the interrupt is never low without an enabled flag pending.

Only the directed scenarios can show the rest: the exact bit positions of each source, the reset value, the read-back of the enable and direction registers, that status writes are ignored, and the one-edge timing of the interrupt around reads and enable changes.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
   localparam logic [7:0] ADDR_STATUS = 8'h03;
   localparam logic [7:0] ADDR_ENABLE = 8'h0A;
   localparam logic [7:0] ADDR_DIR    = 8'h0B;
   localparam logic [7:0] STATUS_RST  = 8'hE0;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N      = 8,
   parameter bit RISING = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] block_i,
   output logic [N-1:0] hit_o
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= src_i;
   end

   for (genvar k = 0; k < N; k++) begin : g_bit
      if (RISING) begin : g_edge
         assign hit_o[k] = src_i[k] & ~prev_q[k] & ~block_i[k];
      end else begin : g_level
         assign hit_o[k] = src_i[k] & ~block_i[k];
      end
   end

   // R2: a flag event always comes from a high input
   a_r2_hit_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o & ~src_i) == '0);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int           N       = 8,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit_i,
   input  logic         clr_i,
   output logic [N-1:0] status_o,
   output logic [N-1:0] status_nxt_o
);
   assign status_nxt_o = (clr_i ? '0 : status_o) | hit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o <= RST_VAL;
      else        status_o <= status_nxt_o;
   end

   // R3: without a read, no flag is lost
   a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (status_o & $past(status_o)) == $past(status_o));
   // R4 / R5: after a read only the same-cycle events remain
   a_r5_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> status_o == $past(hit_i));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int           N      = 8,
   parameter int           ADDR_W = 8,
   parameter logic [7:0]   A_EN   = 8'h0A,
   parameter logic [7:0]   A_DIR  = 8'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N-1:0]      wdata_i,
   output logic [N-1:0]      enable_o,
   output logic [N-1:0]      dir_o
);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(A_EN);
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(A_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_o <= '0;
         dir_o    <= '0;
      end else if (wr_i) begin
         if (addr_i == EN_A)  enable_o <= wdata_i;
         if (addr_i == DIR_A) dir_o    <= wdata_i;
      end
   end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
   import irq_collector_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_SRC  = 8,
   parameter int PIN_LO   = 4,
   parameter bit RISING   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_sel_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [NUM_SRC-1:0] bus_wdata_i,
   output logic [NUM_SRC-1:0] bus_rdata_o,
   output logic               irq_n_o
);
   localparam logic [ADDR_W-1:0] ST_A  = ADDR_W'(ADDR_STATUS);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(ADDR_ENABLE);
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(ADDR_DIR);

   if (NUM_SRC < 1 || NUM_SRC > 8) begin : g_bad_n
      $error("NUM_SRC must be 1..8");
   end
   if (PIN_LO < 0 || PIN_LO >= NUM_SRC) begin : g_bad_pin
      $error("PIN_LO must lie inside the source range");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("ADDR_W too small for the register map");
   end

   logic               rd_acc, wr_acc, clr_status;
   logic [NUM_SRC-1:0] enable_q, dir_q, out_mask, hit, status_q, status_nxt;
   logic               irq_pend;

   assign rd_acc     = bus_sel_i & ~bus_wr_i;
   assign wr_acc     = bus_sel_i &  bus_wr_i;
   assign clr_status = rd_acc & (bus_addr_i == ST_A);

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_mask
      if (k >= PIN_LO) begin : g_pin
         assign out_mask[k] = dir_q[k];
      end else begin : g_fixed
         assign out_mask[k] = 1'b0;
      end
   end

   irq_cfg_regs #(
      .N(NUM_SRC), .ADDR_W(ADDR_W), .A_EN(ADDR_ENABLE), .A_DIR(ADDR_DIR)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_acc), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .enable_o(enable_q), .dir_o(dir_q)
   );

   irq_edge_detect #(.N(NUM_SRC), .RISING(RISING)) u_edge (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .block_i(out_mask), .hit_o(hit)
   );

   irq_status_reg #(.N(NUM_SRC), .RST_VAL(STATUS_RST[NUM_SRC-1:0])) u_status (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr_status),
      .status_o(status_q), .status_nxt_o(status_nxt)
   );

   assign irq_pend = |(status_nxt & enable_q & ~out_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_o <= 1'b1;
      else        irq_n_o <= ~irq_pend;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (rd_acc) begin
         if (bus_addr_i == ST_A)       bus_rdata_o = status_q;
         else if (bus_addr_i == EN_A)  bus_rdata_o = enable_q;
         else if (bus_addr_i == DIR_A) bus_rdata_o = dir_q;
      end
   end

   // R6: no interrupt when nothing was enabled
   a_r6_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |=> irq_n_o);
   // R8: a low interrupt always has an enabled, unmasked flag behind it
   a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_o |-> |(status_q & $past(enable_q & ~out_mask)));
   // R7: output-mode pins never gain a flag
   a_r7_output_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_q & ~$past(status_q) & $past(out_mask)) == '0);
endmodule

// File: tb/irq_collector_tb.sv
module irq_collector_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src = '0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;
   int checks = 0, failures = 0;
   bit done = 0;

   localparam logic [7:0] A_ST = 8'h03, A_EN = 8'h0A, A_DIR = 8'h0B;

   irq_collector u_dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); sel = 1; wr = 0; addr = a;
      #2 d = rdata;
      @(negedge clk); sel = 0;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic pulse(input int k);
      @(negedge clk); src[k] = 1'b1;
      @(negedge clk); src[k] = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      bus_rd(A_ST, d);  chk("R1 status", d, 8'hE0);
      bus_rd(A_ST, d);  chk("R4 cleared", d, 8'h00);
      bus_rd(A_EN, d);  chk("R1 enable", d, 8'h00);
      bus_rd(A_DIR, d); chk("R1 dir", d, 8'h00);
   endtask

   task automatic t_bitmap;
      logic [7:0] d;
      for (int k = 0; k < 8; k++) begin
         pulse(k);
         bus_rd(A_ST, d); chk("R2 bit map", d, 8'(1 << k));
      end
   endtask

   task automatic t_hold_level;
      logic [7:0] d;
      @(negedge clk); src[3] = 1'b1;
      repeat (3) @(negedge clk);
      bus_rd(A_ST, d); chk("R3 held flag", d, 8'h08);
      bus_rd(A_ST, d); chk("R3 no relatch on level", d, 8'h00);
      @(negedge clk); src[3] = 1'b0;
   endtask

   task automatic t_read_race;
      logic [7:0] d;
      pulse(0);
      @(negedge clk); sel = 1; wr = 0; addr = A_ST; src[2] = 1'b1;
      #2 d = rdata;
      @(negedge clk); sel = 0; src[2] = 1'b0;
      chk("R5 race read data", d, 8'h01);
      bus_rd(A_ST, d); chk("R5 event kept", d, 8'h04);
   endtask

   task automatic t_enable_irq;
      logic [7:0] d;
      pulse(0);
      chk("R6 masked flag no irq", {7'd0, irq_n}, 8'h01);
      bus_wr(A_EN, 8'h01);
      chk("R8 irq one edge after enable", {7'd0, irq_n}, 8'h01);
      @(negedge clk);
      chk("R8 irq after enable", {7'd0, irq_n}, 8'h00);
      bus_rd(A_ST, d); chk("R6 latched while masked", d, 8'h01);
      chk("R8 irq high after read", {7'd0, irq_n}, 8'h01);
      bus_wr(A_EN, 8'h06);
      pulse(1);
      chk("R6 OR of enabled", {7'd0, irq_n}, 8'h00);
      bus_rd(A_ST, d);
      pulse(3);
      chk("R6 disabled source", {7'd0, irq_n}, 8'h01);
      bus_rd(A_ST, d); chk("R6 disabled still latched", d, 8'h08);
   endtask

   task automatic t_direction;
      logic [7:0] d;
      bus_wr(A_EN, 8'hFF);
      bus_wr(A_DIR, 8'hF0);
      for (int k = 4; k < 8; k++) pulse(k);
      chk("R7 output pins no irq", {7'd0, irq_n}, 8'h01);
      bus_rd(A_ST, d); chk("R7 output pins no latch", d, 8'h00);
      bus_wr(A_DIR, 8'h00);
      pulse(5);
      chk("R7 input pin irq", {7'd0, irq_n}, 8'h00);
      bus_wr(A_DIR, 8'h20);
      @(negedge clk);
      chk("R7 existing flag masked", {7'd0, irq_n}, 8'h01);
      bus_rd(A_ST, d); chk("R7 flag retained", d, 8'h20);
      bus_wr(A_DIR, 8'h00);
      bus_wr(A_EN, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] d;
      bus_wr(A_EN, 8'h5A);
      bus_rd(A_EN, d); chk("R9 enable readback", d, 8'h5A);
      bus_wr(A_DIR, 8'hA0);
      bus_rd(A_DIR, d); chk("R9 dir readback", d, 8'hA0);
      bus_wr(A_ST, 8'hFF);
      bus_rd(A_ST, d); chk("R9 status write ignored", d, 8'h00);
      bus_wr(A_EN, 8'h00); bus_wr(A_DIR, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bitmap();
      t_hold_level();
      t_read_race();
      t_enable_irq();
      t_direction();
      t_regs();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule